// File: doc/BRIEF.md
# Two-Register Video Port

This block is a CPU-bus slave that exposes a video coprocessor's memory and its control registers through only two bus addresses. One register-select input picks between a data port into video memory and a control port. Video memory is reached through an internal address pointer. The control port takes byte pairs that either load that pointer or write one of a small set of control registers. Every access holds the CPU in a stall for a fixed number of clock cycles while the block finishes the work. The data bus is driven only while a selected read is being answered.

The video memory is a dual-port block RAM. The CPU side uses one port and the display side reads the other port independently. All control registers are presented in parallel to the display logic. A test mode turns both addresses into a single counting byte, so the bus path can be exercised without touching memory or registers.

Top module: `vport_slave`

## Requirements
- R1: An access starts only on a clock edge that samples chip select low while phase-2 is high. Chip select low with phase-2 low starts nothing.
- R2: The data output enable goes high at the start edge of a read and stays high until the first edge that samples chip select high, when it drops. A write never raises it. `bus_dout` is 0 whenever the enable is low.
- R3: `bus_stall` rises at the edge that starts the access and is held for exactly STALL_CYC clock cycles (default 3).
- R4: After an access completes, no further access starts until chip select has been sampled high, even if chip select stays low with phase-2 high.
- R5: With select 0, a read returns the video memory byte at the pointer and a write stores the latched bus byte there. Both increment the pointer by one, modulo 2^AW.
- R6: Control port writes come in pairs. The first byte is held. If bit 7 of the second byte is 0, the pointer becomes {second byte bits 6..0, first byte} truncated to AW bits. If bit 7 is 1, the first byte is written to the register whose index is the low log2(NREG) bits of the second byte, and that register becomes the selected one.
- R7: A control port read returns the selected register (register 0 after reset). It also resets the pair tracking, so the next control write is taken as a first byte.
- R8: In test mode, a read from either address returns the test byte and then increments it. A write to either address loads the test byte. Video memory, the pointer, the registers and the pair tracking are left unchanged.
- R9: `vid_q` returns the video memory byte at `vid_addr` one clock later, regardless of CPU activity.
- R10: After reset, stall and output enable are low, the data output is 0, and the pointer, test byte, selected index and all registers are 0.
- R11: `reg_q` holds register n at bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_phi2 | input | 1 | CPU phase-2 clock level |
| bus_rwb | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 1 | Register select: 0 video data port, 1 control port |
| test_en | input | 1 | Test mode enable, sampled at access start |
| bus_din | input | 8 | Write data from the CPU |
| bus_dout | output | 8 | Read data to the CPU |
| bus_doe | output | 1 | Data output enable for the bus transceiver |
| bus_stall | output | 1 | Stall request to the CPU |
| vid_addr | input | AW | Display-side video memory address |
| vid_q | output | 8 | Display-side video memory data |
| reg_q | output | NREG*8 | All control registers, flattened |

## Verification
The assertions assume that the bus inputs are already synchronous to `clk`. They also assume that the CPU keeps chip select low and the write data stable until the stall drops, so the byte latched at the start edge is the one intended. The stimulus changes bus inputs only on falling clock edges and holds each access until it sees the stall release. It then raises chip select for at least one edge, except in the case that deliberately holds chip select low to probe R4. Test mode is changed only between accesses, because it is sampled only at the start edge.

// File: rtl/vport_pkg.sv
package vport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_HOLD
  } seq_st_e;

  // attributes of the access in flight, latched at the start edge
  typedef struct packed {
    logic ctl;  // control port (select = 1)
    logic rd;   // read
    logic tst;  // test mode
  } acc_t;

endpackage

// File: rtl/vport_seq.sv
module vport_seq
  import vport_pkg::*;
#(
  parameter int STALL_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic phi2,
  input  logic rwb,
  input  logic rs,
  input  logic tst_en,
  output logic start,
  output logic finish,
  output logic drop,
  output acc_t acc,
  output logic stall,
  output logic doe
);

  localparam int CW = (STALL_CYC > 1) ? $clog2(STALL_CYC) : 1;
  localparam int RW = $clog2(STALL_CYC + 2);

  seq_st_e       st;
  logic [CW-1:0] cnt;
  logic          hit;

  assign hit    = !cs_n && phi2;
  assign start  = (st == ST_IDLE) && hit;
  assign finish = (st == ST_BUSY) && (cnt == '0);
  assign drop   = (st == ST_HOLD) && cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      stall <= 1'b0;
      doe   <= 1'b0;
      acc   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (hit) begin
          st    <= ST_BUSY;
          stall <= 1'b1;
          doe   <= rwb;
          acc   <= '{ctl: rs, rd: rwb, tst: tst_en};
          cnt   <= CW'(STALL_CYC - 1);
        end
        ST_BUSY: if (cnt == '0) begin
          st    <= ST_HOLD;
          stall <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_HOLD: if (cs_n) begin
          st  <= ST_IDLE;
          doe <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // length of the current stall run, kept for the stall-length property
  logic [RW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else     run <= stall ? run + 1'b1 : '0;
  end

  a_r3_stall_on_access: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(!cs_n && phi2));

  a_r3_stall_length: assert property (@(posedge clk) disable iff (rst)
    ($fell(stall)) |-> (run == RW'(STALL_CYC)));

  a_r4_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(st == ST_IDLE));

  a_r2_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    $rose(doe) |-> $past(rwb));

  a_r2_release_on_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(doe) |-> $past(cs_n));

endmodule

// File: rtl/vport_regs.sv
module vport_regs
  import vport_pkg::*;
#(
  parameter int AW   = 10,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              finish,
  input  logic              drop,
  input  acc_t              acc,
  input  logic              rs,
  input  logic              rwb,
  input  logic              tst_en,
  input  logic [7:0]        din,
  input  logic [7:0]        vq,
  output logic [AW-1:0]     ptr,
  output logic              mem_we,
  output logic [7:0]        wd,
  output logic [7:0]        dout,
  output logic [NREG*8-1:0] reg_q
);

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0]    rf [NREG];
  logic [7:0]    lat;
  logic [7:0]    tbyte;
  logic [IW-1:0] sel;
  logic          flag;
  logic [7:0]    rd_val;

  always_comb begin
    if (tst_en)  rd_val = tbyte;
    else if (rs) rd_val = rf[sel];
    else         rd_val = vq;
  end

  assign mem_we = finish && !acc.ctl && !acc.rd && !acc.tst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      lat   <= '0;
      tbyte <= '0;
      sel   <= '0;
      flag  <= 1'b0;
      wd    <= '0;
      dout  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (start) begin
        wd   <= din;
        dout <= rwb ? rd_val : 8'h00;
      end else if (drop) begin
        dout <= 8'h00;
      end
      if (finish) begin
        if (acc.tst) begin
          if (acc.rd) tbyte <= tbyte + 1'b1;
          else        tbyte <= wd;
        end else if (!acc.ctl) begin
          ptr <= ptr + 1'b1;
        end else if (acc.rd) begin
          flag <= 1'b0;
        end else if (!flag) begin
          lat  <= wd;
          flag <= 1'b1;
        end else begin
          flag <= 1'b0;
          if (wd[7]) begin
            rf[wd[IW-1:0]] <= lat;
            sel            <= wd[IW-1:0];
          end else begin
            ptr <= AW'({wd[6:0], lat});
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_regq
    assign reg_q[g*8 +: 8] = rf[g];
  end

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (finish && !acc.ctl && !acc.tst) |=> (ptr == AW'($past(ptr) + 1'b1)));

  a_r7_read_clears_pair: assert property (@(posedge clk) disable iff (rst)
    (finish && acc.ctl && acc.rd && !acc.tst) |=> !flag);

  a_r8_test_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (finish && acc.tst) |=> $stable(ptr));

  a_r8_test_keeps_pair: assert property (@(posedge clk) disable iff (rst)
    (finish && acc.tst) |=> $stable(flag));

endmodule

// File: rtl/vport_vram.sv
module vport_vram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wd,
  output logic [7:0]    a_q,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_q
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/vport_slave.sv
module vport_slave
  import vport_pkg::*;
#(
  parameter int AW        = 10,
  parameter int NREG      = 8,
  parameter int STALL_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_phi2,
  input  logic              bus_rwb,
  input  logic              bus_rs,
  input  logic              test_en,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  output logic              bus_doe,
  output logic              bus_stall,
  input  logic [AW-1:0]     vid_addr,
  output logic [7:0]        vid_q,
  output logic [NREG*8-1:0] reg_q
);

  logic          start, finish, drop;
  acc_t          acc;
  logic [AW-1:0] ptr;
  logic          mem_we;
  logic [7:0]    wd;
  logic [7:0]    vq;

  vport_seq #(.STALL_CYC(STALL_CYC)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (bus_cs_n),
    .phi2   (bus_phi2),
    .rwb    (bus_rwb),
    .rs     (bus_rs),
    .tst_en (test_en),
    .start  (start),
    .finish (finish),
    .drop   (drop),
    .acc    (acc),
    .stall  (bus_stall),
    .doe    (bus_doe)
  );

  vport_regs #(.AW(AW), .NREG(NREG)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .finish (finish),
    .drop   (drop),
    .acc    (acc),
    .rs     (bus_rs),
    .rwb    (bus_rwb),
    .tst_en (test_en),
    .din    (bus_din),
    .vq     (vq),
    .ptr    (ptr),
    .mem_we (mem_we),
    .wd     (wd),
    .dout   (bus_dout),
    .reg_q  (reg_q)
  );

  vport_vram #(.AW(AW)) u_vram (
    .clk    (clk),
    .a_we   (mem_we),
    .a_addr (ptr),
    .a_wd   (wd),
    .a_q    (vq),
    .b_addr (vid_addr),
    .b_q    (vid_q)
  );

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !bus_doe |-> (bus_dout == 8'h00));

endmodule

// File: tb/tb_vport_slave.sv
module tb_vport_slave;

  localparam int AW    = 10;
  localparam int NREG  = 8;
  localparam int STALL = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              bus_cs_n = 1'b1;
  logic              bus_phi2 = 1'b0;
  logic              bus_rwb = 1'b1;
  logic              bus_rs = 1'b0;
  logic              test_en = 1'b0;
  logic [7:0]        bus_din = 8'h00;
  logic [7:0]        bus_dout;
  logic              bus_doe;
  logic              bus_stall;
  logic [AW-1:0]     vid_addr = '0;
  logic [7:0]        vid_q;
  logic [NREG*8-1:0] reg_q;

  vport_slave #(.AW(AW), .NREG(NREG), .STALL_CYC(STALL)) dut (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_phi2(bus_phi2),
    .bus_rwb(bus_rwb), .bus_rs(bus_rs), .test_en(test_en), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_stall(bus_stall),
    .vid_addr(vid_addr), .vid_q(vid_q), .reg_q(reg_q)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 stalled, 2 waiting for chip select high
  int m_st = 0, m_cnt = 0, m_dout = 0, m_wd = 0;
  bit m_stall = 0, m_doe = 0, m_ctl = 0, m_rd = 0, m_tst = 0;
  int m_ptr = 0, m_lat = 0, m_sel = 0, m_tb = 0, m_vq = 0;
  bit m_pair = 0;
  int m_rf [NREG];
  int m_mem [DEPTH];
  bit cmp_on = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    for (int i = 0; i < NREG; i++) m_rf[i] = 0;
  end

  always @(posedge clk) begin : model
    int vnext;
    vnext = m_mem[vid_addr];
    if (rst) begin
      m_st = 0; m_cnt = 0; m_stall = 0; m_doe = 0; m_dout = 0;
      m_ptr = 0; m_lat = 0; m_sel = 0; m_tb = 0; m_pair = 0;
      for (int i = 0; i < NREG; i++) m_rf[i] = 0;
    end else if (m_st == 0) begin
      if (!bus_cs_n && bus_phi2) begin
        m_st = 1; m_stall = 1; m_cnt = STALL - 1;
        m_ctl = bus_rs; m_rd = bus_rwb; m_tst = test_en; m_wd = bus_din;
        m_doe = bus_rwb;
        if (!bus_rwb)     m_dout = 0;
        else if (test_en) m_dout = m_tb;
        else if (bus_rs)  m_dout = m_rf[m_sel];
        else              m_dout = m_mem[m_ptr];
      end
    end else if (m_st == 1) begin
      if (m_cnt > 0) m_cnt--;
      else begin
        m_st = 2; m_stall = 0;
        if (m_tst) begin
          m_tb = m_rd ? (m_tb + 1) % 256 : m_wd;
        end else if (!m_ctl) begin
          if (!m_rd) m_mem[m_ptr] = m_wd;
          m_ptr = (m_ptr + 1) % DEPTH;
        end else if (m_rd) begin
          m_pair = 0;
        end else if (!m_pair) begin
          m_lat = m_wd; m_pair = 1;
        end else begin
          m_pair = 0;
          if (m_wd >= 128) begin
            m_rf[m_wd % NREG] = m_lat;
            m_sel = m_wd % NREG;
          end else begin
            m_ptr = ((m_wd % 128) * 256 + m_lat) % DEPTH;
          end
        end
      end
    end else begin
      if (bus_cs_n) begin
        m_st = 0; m_doe = 0; m_dout = 0;
      end
    end
    m_vq = vnext;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(bus_stall == m_stall, "R3 stall vs model", bus_stall, m_stall);
      chk(bus_doe == m_doe, "R2 output enable vs model", bus_doe, m_doe);
      chk(bus_dout == m_dout[7:0], "R5 read data vs model", bus_dout, m_dout);
      chk(vid_q == m_vq[7:0], "R9 display read vs model", vid_q, m_vq);
      for (int n = 0; n < NREG; n++)
        chk(reg_q[n*8 +: 8] == m_rf[n][7:0], "R11 register output vs model",
            reg_q[n*8 +: 8], m_rf[n]);
    end
  end

  int  last_stall;
  bit  last_doe_wr;

  task automatic access(input bit rs, input bit rd, input int wdat, input bit tst,
                        input int hold, output int rdat);
    @(negedge clk);
    bus_rs = rs; bus_rwb = rd; bus_din = wdat[7:0]; test_en = tst;
    bus_cs_n = 1'b0; bus_phi2 = 1'b1;
    last_stall = 0; last_doe_wr = 0;
    @(negedge clk);
    while (bus_stall && last_stall < 50) begin
      last_stall++;
      if (!rd && bus_doe) last_doe_wr = 1;
      @(negedge clk);
    end
    rdat = bus_dout;
    if (!rd && bus_doe) last_doe_wr = 1;
    for (int h = 0; h < hold; h++) begin
      if (bus_stall) last_stall += 100;
      @(negedge clk);
    end
    bus_cs_n = 1'b1; bus_phi2 = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit rs, input int d);
    int unused;
    access(rs, 1'b0, d, 1'b0, 0, unused);
  endtask

  task automatic rdp(input bit rs, output int d);
    access(rs, 1'b1, 0, 1'b0, 0, d);
  endtask

  task automatic run_tests();
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1;
    // R10 reset state
    chk(bus_stall == 0 && bus_doe == 0 && bus_dout == 0, "R10 idle outputs after reset",
        {bus_stall, bus_doe, bus_dout}, 0);
    chk(reg_q == '0, "R10 registers clear after reset", reg_q[31:0], 0);

    // R1 chip select without phase-2 starts nothing
    @(negedge clk);
    bus_cs_n = 1'b0; bus_phi2 = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(bus_stall == 0, "R1 no start with phase-2 low", bus_stall, 0);
    end
    bus_cs_n = 1'b1;

    // R6 pointer load, R5 writes, R2 no drive on write, R3 stall length
    wr(1, 8'h34); wr(1, 8'h01);
    wr(0, 8'hA1);
    chk(last_stall == STALL, "R3 stall length on write", last_stall, STALL);
    chk(last_doe_wr == 0, "R2 no drive during write", last_doe_wr, 0);
    wr(0, 8'hA2); wr(0, 8'hA3);
    wr(1, 8'h34); wr(1, 8'h01);
    rdp(0, v); chk(v == 8'hA1, "R5 read at loaded pointer", v, 8'hA1);
    chk(last_stall == STALL, "R3 stall length on read", last_stall, STALL);
    rdp(0, v); chk(v == 8'hA2, "R5 read after increment", v, 8'hA2);
    rdp(0, v); chk(v == 8'hA3, "R5 third sequential read", v, 8'hA3);

    // R9 display port independent of CPU side
    vid_addr = 10'h135;
    @(negedge clk); @(negedge clk);
    chk(vid_q == 8'hA2, "R9 display port reads memory", vid_q, 8'hA2);

    // R6 register write and R11 placement
    wr(1, 8'h5A); wr(1, 8'h83);
    chk(reg_q[31:24] == 8'h5A, "R11 register 3 position", reg_q[31:24], 8'h5A);
    rdp(1, v); chk(v == 8'h5A, "R7 control read returns selected register", v, 8'h5A);

    // R7 control read resets the pair tracking
    wr(1, 8'h11);
    rdp(1, v);
    wr(1, 8'h22); wr(1, 8'h85);
    chk(reg_q[47:40] == 8'h22, "R7 pair restarted after control read", reg_q[47:40], 8'h22);

    // R5 pointer wrap
    wr(1, 8'hFF); wr(1, 8'h03);
    wr(0, 8'hB7); wr(0, 8'hB8);
    wr(1, 8'hFF); wr(1, 8'h03);
    rdp(0, v); chk(v == 8'hB7, "R5 top address", v, 8'hB7);
    rdp(0, v); chk(v == 8'hB8, "R5 pointer wraps to zero", v, 8'hB8);

    // R8 test mode leaves memory, pointer, registers and pairing alone
    wr(1, 8'h35); wr(1, 8'h01);
    wr(1, 8'h66);
    access(1, 1'b0, 8'h40, 1'b1, 0, v);
    access(0, 1'b1, 0, 1'b1, 0, v);
    chk(v == 8'h40, "R8 test byte loaded", v, 8'h40);
    access(1, 1'b1, 0, 1'b1, 0, v);
    chk(v == 8'h41, "R8 test byte increments", v, 8'h41);
    test_en = 1'b0;
    wr(1, 8'h86);
    chk(reg_q[55:48] == 8'h66, "R8 pair tracking kept across test mode", reg_q[55:48], 8'h66);
    rdp(0, v); chk(v == 8'hA2, "R8 pointer kept across test mode", v, 8'hA2);

    // R4 holding chip select low does not restart
    access(0, 1'b1, 0, 1'b0, 6, v);
    chk(last_stall == STALL, "R4 no restart while chip select stays low", last_stall, STALL);
    chk(v == 8'hA3, "R5 read during held select", v, 8'hA3);
    @(negedge clk);
    chk(bus_doe == 0 && bus_dout == 0, "R2 released after chip select high",
        {bus_doe, bus_dout}, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R3 actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule